// File: doc/BRIEF.md
# Event-Flag Serial Port

A byte-wide asynchronous serial port on a 32-bit word register bus. Software sets a bit rate divisor, writes bytes to the data register to send them, and reads received bytes from the same address. The transmitter and the receiver share one tick stream with sixteen ticks per bit. The transmitter sends 8N1 frames. The receiver oversamples the line and takes each bit at its middle.

Progress is reported through a status register. It holds a level that shows whether the transmitter can accept a byte, and two sticky event flags, one for a received byte and one for a finished transmission. Software clears each flag by writing a one to it. One interrupt line combines the two flags, each gated by its own enable in the control register. A third control bit makes the serial output copy the serial input directly.

Top module: `evt_uart`

## Requirements
- R1: The word registers are selected by bus address bits [3:2]. 0x0 is data: a write sends a byte, a read returns the last good received byte in bits [7:0]. 0x4 is the divisor. 0x8 is status, with bit 0 transmitter ready, bit 1 receive event and bit 2 transmit event. 0xC is control, with bit 0 receive interrupt enable, bit 1 transmit interrupt enable and bit 2 loop-through. Unused read bits are 0.
- R2: With divisor D nonzero, a tick occurs once every D clocks, and the count restarts when the divisor is written. With D = 0 no ticks occur. One bit lasts 16 ticks.
- R3: A data write while the transmitter is ready drives the line low (start bit) from the next cycle. It then sends the 8 data bits LSB first and a high stop bit, each lasting 16 ticks. The line is high when idle.
- R4: Status bit 0 goes to 0 on the cycle after an accepted data write. It returns to 1 when the stop bit's 16th tick ends. A data write while it is 0 is ignored.
- R5: Status bit 2 becomes 1 on the same edge at which the transmitter becomes ready again.
- R6: The receiver starts on a falling edge of the input and samples at the 8th tick of each bit. If the start sample is high, the frame is abandoned. A valid frame stores the byte for offset 0 and sets status bit 1.
- R7: A frame whose stop sample is low is dropped: status bit 1 stays 0 and the stored byte is unchanged.
- R8: Writing 1 to status bit 1 or 2 clears that flag, and writing 0 leaves it unchanged. If an event and a clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R9: irq_o is 1 exactly while (status bit 1 and control bit 0) or (status bit 2 and control bit 1).
- R10: With control bit 2 set, txd_o equals rxd_i in the same cycle. With it clear, txd_o is the transmitter's line.
- R11: After reset the status register reads 0x1, control and divisor read 0, irq_o is 0 and txd_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 4 | Byte address of the word register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| irq_o | output | 1 | Combined interrupt |

## Verification
A transmit-done event and a software clear of the same flag can fall on one clock edge, and set must win. The bench runs a reference model of the tick count and the frame. It uses this model to find the exact cycle in which the stop bit ends, and it issues the write-one clear to status bit 2 in that cycle. It then reads the flag back and expects 1. The model also compares the line level, the ready bit and the transmit flag on every clock, through normal sends and through a write issued while a send is in progress.

// File: rtl/evt_uart_pkg.sv
`timescale 1ns/1ps
package evt_uart_pkg;
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_DIV  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int ST_READY = 0;
  localparam int ST_RXEV  = 1;
  localparam int ST_TXEV  = 2;

  localparam int CT_RXIE = 0;
  localparam int CT_TXIE = 1;
  localparam int CT_THRU = 2;

  localparam int TICKS_PER_BIT = 16;
  localparam int FRAME_BITS    = 10;

  typedef enum logic [0:0] {RX_IDLE, RX_RUN} rx_state_e;
endpackage

// File: rtl/evt_uart_tick.sv
`timescale 1ns/1ps
module evt_uart_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (div_i != '0) && (cnt_q == div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (tick_o)          cnt_q <= '0;
    else if (div_i != '0)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_uart_tx.sv
`timescale 1ns/1ps
module evt_uart_tx
  import evt_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              txd_o
);
  localparam int FW    = DATA_W + 2;
  localparam int PH_W  = $clog2(TICKS_PER_BIT);
  localparam int BIT_W = $clog2(FW + 1);

  logic [FW-1:0]    frame_q;
  logic [PH_W-1:0]  ph_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy_q, txd_q;
  logic             bit_end;

  assign bit_end = busy_q && tick_i && (ph_q == PH_W'(TICKS_PER_BIT - 1));
  assign done_o  = bit_end && (bit_q == BIT_W'(FW - 1));
  assign busy_o  = busy_q;
  assign txd_o   = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      ph_q    <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else if (load_i && !busy_q) begin
      frame_q <= {1'b1, data_i, 1'b0};
      ph_q    <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b1;
      txd_q   <= 1'b0;
    end else if (busy_q && tick_i) begin
      ph_q <= ph_q + 1'b1;
      if (done_o) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end else if (bit_end) begin
        bit_q <= bit_q + 1'b1;
        txd_q <= frame_q[bit_q + 1'b1];
      end
    end
  end
endmodule

// File: rtl/evt_uart_rx.sv
`timescale 1ns/1ps
module evt_uart_rx
  import evt_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int PH_W  = $clog2(TICKS_PER_BIT);
  localparam int BIT_W = $clog2(DATA_W + 3);
  localparam int MID   = TICKS_PER_BIT / 2 - 1;

  logic [2:0]        sync_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic [PH_W-1:0]   ph_q;
  logic [BIT_W-1:0]  bit_q;
  logic              valid_q;
  rx_state_e         st_q;
  logic              line, fall, sample;

  assign line    = sync_q[1];
  assign fall    = sync_q[2] && !sync_q[1];
  assign sample  = (st_q == RX_RUN) && tick_i && (ph_q == PH_W'(MID));
  assign valid_o = valid_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      sh_q    <= '0;
      data_q  <= '0;
      ph_q    <= '0;
      bit_q   <= '0;
      valid_q <= 1'b0;
      st_q    <= RX_IDLE;
    end else begin
      sync_q  <= {sync_q[1:0], rxd_i};
      valid_q <= 1'b0;
      if (st_q == RX_IDLE) begin
        if (fall) begin
          st_q  <= RX_RUN;
          ph_q  <= '0;
          bit_q <= '0;
        end
      end else if (tick_i) begin
        ph_q <= ph_q + 1'b1;
        if (sample) begin
          bit_q <= bit_q + 1'b1;
          if (bit_q == '0) begin
            if (line) st_q <= RX_IDLE;  // false start
          end else if (bit_q == BIT_W'(DATA_W + 1)) begin
            st_q <= RX_IDLE;
            if (line) begin
              data_q  <= sh_q;
              valid_q <= 1'b1;
            end
          end else begin
            sh_q <= {line, sh_q[DATA_W-1:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/evt_uart.sv
`timescale 1ns/1ps
module evt_uart
  import evt_uart_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic        irq_o
);
  logic [DIV_W-1:0]  div_q;
  logic [2:0]        ctrl_q;
  logic              rx_evt_q, tx_evt_q;
  logic              tick, tx_busy, tx_done, tx_line, rx_valid;
  logic [DATA_W-1:0] rx_data;
  logic              data_wr, div_wr, stat_wr, ctrl_wr;

  assign data_wr = wr_en_i && (addr_i[3:2] == REG_DATA);
  assign div_wr  = wr_en_i && (addr_i[3:2] == REG_DIV);
  assign stat_wr = wr_en_i && (addr_i[3:2] == REG_STAT);
  assign ctrl_wr = wr_en_i && (addr_i[3:2] == REG_CTRL);

  evt_uart_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i(div_q), .restart_i(div_wr), .tick_o(tick)
  );

  evt_uart_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(data_wr),
    .data_i(wdata_i[DATA_W-1:0]), .busy_o(tx_busy), .done_o(tx_done),
    .txd_o(tx_line)
  );

  evt_uart_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i, .valid_o(rx_valid), .data_o(rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= '0;
      ctrl_q   <= '0;
      rx_evt_q <= 1'b0;
      tx_evt_q <= 1'b0;
    end else begin
      if (div_wr)  div_q  <= wdata_i[DIV_W-1:0];
      if (ctrl_wr) ctrl_q <= wdata_i[2:0];
      // event wins over a clear in the same cycle
      rx_evt_q <= (rx_evt_q && !(stat_wr && wdata_i[ST_RXEV])) || rx_valid;
      tx_evt_q <= (tx_evt_q && !(stat_wr && wdata_i[ST_TXEV])) || tx_done;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i[3:2])
      REG_DATA: rdata_o[DATA_W-1:0] = rx_data;
      REG_DIV:  rdata_o[DIV_W-1:0]  = div_q;
      REG_STAT: rdata_o[2:0]        = {tx_evt_q, rx_evt_q, !tx_busy};
      default:  rdata_o[2:0]        = ctrl_q;
    endcase
  end

  assign irq_o = (rx_evt_q && ctrl_q[CT_RXIE]) || (tx_evt_q && ctrl_q[CT_TXIE]);
  assign txd_o = ctrl_q[CT_THRU] ? rxd_i : tx_line;
endmodule

// File: rtl/evt_uart_chk.sv
`timescale 1ns/1ps
module evt_uart_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_wr,
  input logic             stat_wr,
  input logic [31:0]      wdata_i,
  input logic             tx_busy,
  input logic             tx_done,
  input logic             tx_evt,
  input logic             tick,
  input logic [DIV_W-1:0] div_q,
  input logic             thru,
  input logic             txd_o
);
  // R4
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && !tx_busy |=> tx_busy);

  // R5
  txev_on_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_busy) |-> tx_evt);

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done |=> tx_evt);

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_evt && !(stat_wr && wdata_i[2]) |=> tx_evt);

  // R2
  no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0) |-> !tick);

  // R3
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thru && !tx_busy && !$past(data_wr) |-> txd_o);
endmodule

bind evt_uart evt_uart_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_wr(data_wr), .stat_wr(stat_wr),
  .wdata_i(wdata_i), .tx_busy(tx_busy), .tx_done(tx_done), .tx_evt(tx_evt_q),
  .tick(tick), .div_q(div_q), .thru(ctrl_q[2]), .txd_o(txd_o)
);

// File: tb/tb_evt_uart.sv
`timescale 1ns/1ps
module tb_evt_uart;
  localparam logic [3:0] A_DATA = 4'h0, A_DIV = 4'h4, A_STAT = 4'h8, A_CTRL = 4'hC;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = A_STAT;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rxd_i = 1'b1;
  logic        txd_o, irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] v;

  evt_uart dut (.clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
                .rxd_i, .txd_o, .irq_o);

  always #2 clk = ~clk;

  // behavioural reference of tick stream, transmitter and tx flag
  int m_div = 0, m_cnt = 0, m_ph = 0, m_bit = 0;
  bit m_busy = 0, m_txev = 0, m_thru = 0, m_live = 0;
  bit [9:0] m_frame = '1;

  always @(posedge clk) if (rst_ni) begin
    bit tk, pre, done;
    tk = (m_div != 0) && (m_cnt == m_div - 1);
    pre = m_busy;
    done = 0;
    if (pre && tk) begin
      m_ph++;
      if (m_ph == 16) begin
        m_ph = 0; m_bit++;
        if (m_bit == 10) begin m_busy = 0; done = 1; end
      end
    end
    if (!pre && wr_en_i && addr_i[3:2] == 0) begin
      m_busy = 1; m_frame = {1'b1, wdata_i[7:0], 1'b0}; m_ph = 0; m_bit = 0;
    end
    if (wr_en_i && addr_i[3:2] == 1) m_cnt = 0;
    else if (tk) m_cnt = 0;
    else if (m_div != 0) m_cnt++;
    if (wr_en_i && addr_i[3:2] == 1) m_div = int'(wdata_i[15:0]);
    if (wr_en_i && addr_i[3:2] == 3) m_thru = wdata_i[2];
    m_txev = (m_txev && !(wr_en_i && addr_i[3:2] == 2 && wdata_i[2])) || done;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, 1 ns before the next rising edge
  always @(posedge clk) if (m_live) begin
    #3;
    check("R3/R10 line", {31'b0, txd_o},
          {31'b0, m_thru ? rxd_i : (m_busy ? m_frame[m_bit] : 1'b1)});
    if (!wr_en_i && addr_i == A_STAT) begin
      check("R4 ready", {31'b0, rdata_o[0]}, {31'b0, !m_busy});
      check("R5 tx flag", {31'b0, rdata_o[2]}, {31'b0, m_txev});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0; addr_i = A_STAT;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr_i = a; #1 d = rdata_o;
    @(negedge clk); addr_i = A_STAT;
  endtask

  task automatic wait_tx_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop_bit);
    logic [9:0] f;
    f = {stop_bit, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd_i = f[i];
      repeat (16 * m_div - 1) @(negedge clk);
    end
    @(negedge clk); rxd_i = 1'b1;
    repeat (16 * m_div) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    #1;
    check("R11 txd", {31'b0, txd_o}, 32'd1);
    check("R11 irq", {31'b0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    rd(A_STAT, v); check("R11 status", v, 32'h1);
    rd(A_CTRL, v); check("R11 ctrl", v, 32'h0);
    rd(A_DIV, v);  check("R11 div", v, 32'h0);
    m_live = 1;

    // R1 R2 divisor readback
    wr(A_DIV, 32'd2);
    rd(A_DIV, v); check("R1 div readback", v, 32'd2);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, v); check("R1 ctrl readback", v, 32'h2);

    // R3 R4 send, with an ignored write mid-frame
    wr(A_DATA, 32'hA5);
    repeat (100) @(negedge clk);
    wr(A_DATA, 32'h3C);
    wait_tx_idle();
    rd(A_STAT, v); check("R5 flag after send", v, 32'h5);
    check("R9 tx irq", {31'b0, irq_o}, 32'd1);

    // R8 write 0 has no effect, write 1 clears
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R8 w0 keeps", v, 32'h5);
    wr(A_STAT, 32'h4);
    rd(A_STAT, v); check("R8 w1 clears", v, 32'h1);
    check("R9 irq low", {31'b0, irq_o}, 32'd0);

    // R8 clear in the very cycle of the transmit event
    wr(A_DATA, 32'h81);
    while (!(m_busy && m_ph == 15 && m_bit == 9 && m_cnt == m_div - 1)) @(negedge clk);
    wr_en_i = 1'b1; addr_i = A_STAT; wdata_i = 32'h4;
    @(negedge clk); wr_en_i = 1'b0;
    #1 check("R8 set wins", {31'b0, rdata_o[2]}, 32'd1);
    wr(A_STAT, 32'h4);

    // R6 receive, R9 rx interrupt
    wr(A_CTRL, 32'h1);
    send_rx(8'h5A, 1'b1);
    rd(A_STAT, v); check("R6 rx flag", v, 32'h3);
    check("R9 rx irq", {31'b0, irq_o}, 32'd1);
    rd(A_DATA, v); check("R6 rx data", v, 32'h5A);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R8 rx clear", v, 32'h1);
    check("R9 irq off", {31'b0, irq_o}, 32'd0);

    // R7 bad stop bit dropped
    send_rx(8'hC3, 1'b0);
    rd(A_STAT, v); check("R7 no flag", v, 32'h1);
    rd(A_DATA, v); check("R7 data kept", v, 32'h5A);

    // R2 R3 R6 other divisor
    wr(A_DIV, 32'd3);
    wr(A_DATA, 32'h6E);
    wait_tx_idle();
    wr(A_STAT, 32'h4);
    send_rx(8'h0F, 1'b1);
    rd(A_DATA, v); check("R6 rx div3", v, 32'h0F);
    wr(A_STAT, 32'h2);

    // R10 loop-through
    wr(A_CTRL, 32'h4);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); rxd_i = i[0];
      #1 check("R10 thru", {31'b0, txd_o}, {31'b0, rxd_i});
    end
    @(negedge clk); rxd_i = 1'b1;
    wr(A_CTRL, 32'h0);
    repeat (4) @(negedge clk);
    check("R10 off idle", {31'b0, txd_o}, 32'd1);

    m_live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule